// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Keyed Restart

This block is a watchdog timer that sits on an 8-bit peripheral register bus. A down-counter is decremented once per prescaler period. The prescaler divides the clock by a power of two that a 3-bit select field chooses. Software must restart the count before it runs out. The only way to restart it is a two-write keyed sequence to a pair of dedicated restart registers. This keeps a runaway program that scribbles over the register space from keeping the watchdog alive by accident.

When the count runs out, the block raises a one-cycle reset request for the reset network and sets a timeout flag. The flag sits in a flop that is cleared only by power-on reset, so it survives the system reset that the request triggers. The control register therefore reports after that reset whether the watchdog caused it. Stopping the watchdog is also guarded: clearing the run bit is only remembered, and it takes effect at the next valid restart.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset (por_ni and rst_ni both low), the control register (address 0) reads 0xE4 and the reload register (address 1) reads 0x00. The control layout is: bits 7:5 prescaler select, bit 2 run, bit 1 timeout flag, bits 4, 3 and 0 read 0.
- R2: After a system reset that follows a reset request from the block, control reads 0xE6. After any later system reset with no request in between, it reads 0xE4 again.
- R3: With run set, wd_rst_req_o goes high for exactly one cycle, (reload+1)·2^(select+5) clock edges after the last restart, run-enable write, or reset release.
- R4: A restart is a write of 0xA5 to address 2, followed by a write of 0x5A to address 3 as the very next bus access. It clears the prescaler and loads the counter from the reload register. A read, any other write, wrong data, or the wrong order in between loads nothing.
- R5: The timeout flag (control bit 1) is set when the reset request fires. A control write with bit 1 = 0 clears it. A control write with bit 1 = 1 does not set it.
- R6: A control write with bit 2 = 1 sets run at once. A control write with bit 2 = 0 leaves run set until the next valid restart, which then clears it. While run is clear, no reset request is issued.
- R7: Only bits 7:0 of the 16-bit write data are used. Addresses 2 and 3 read as 0x00.
- R8: After a timeout, the counter reloads and keeps running, so without a restart the next request follows one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset, also clears the timeout flag |
| bus_sel_i | input | 1 | Register access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 control, 1 reload, 2 restart key A, 3 restart key B |
| bus_wdata_i | input | 16 | Write data, only the low byte is used |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| wd_rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions watch, on every cycle, that the reset request is a single-cycle pulse and that the timeout flag is set whenever it fires. They also check that no request leaves a stopped watchdog, that run falls only at a valid restart, that a restart loads the counter from the reload register, and that the unused control bits read zero. Only the bench scenarios can show the exact timeout period for every prescaler select. The same holds for the rejection of each malformed restart sequence and for the flag's survival across one system reset but not the next.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_KEY_A  = 2'd2,
    REG_KEY_B  = 2'd3
  } wdog_addr_e;

  localparam logic [7:0] KEY_A_VAL = 8'hA5;
  localparam logic [7:0] KEY_B_VAL = 8'h5A;
  localparam int RUN_BIT  = 2;
  localparam int FLAG_BIT = 1;
endpackage

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             feed_o
);
  logic armed_q;
  logic key_a_hit;

  assign key_a_hit = acc_i && we_i && (addr_i == REG_KEY_A) && (wdata_i == REG_W'(KEY_A_VAL));
  assign feed_o    = armed_q && acc_i && we_i && (addr_i == REG_KEY_B) &&
                     (wdata_i == REG_W'(KEY_B_VAL));

  // any access re-evaluates the arm; idle cycles keep it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (acc_i) armed_q <= key_a_hit;
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SEL_W    = 3,
  parameter int PRE_BASE = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = PRE_BASE + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < (int'(sel_i) + PRE_BASE));
  end

  assign tick_o = run_i && (&(pre_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (run_i)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // restart wins over an expiry in the same cycle
  assign expire_o = tick_i && (cnt_q == '0) && !load_i;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= reload_i;
    else if (expire_o) cnt_q <= reload_i;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             feed_i,
  input  logic             flag_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             run_o,
  output logic [REG_W-1:0] reload_o,
  output logic             flag_clr_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [SEL_W-1:0] sel_q;
  logic             run_q;
  logic             stop_pend_q;
  logic [REG_W-1:0] reload_q;
  logic             ctrl_wr;

  assign ctrl_wr    = acc_i && we_i && (addr_i == REG_CTRL);
  assign flag_clr_o = ctrl_wr && !wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '1;
      run_q       <= 1'b1;
      stop_pend_q <= 1'b0;
      reload_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        sel_q <= wdata_i[REG_W-1 -: SEL_W];
        if (wdata_i[RUN_BIT]) begin
          run_q       <= 1'b1;
          stop_pend_q <= 1'b0;
        end else begin
          stop_pend_q <= 1'b1;
        end
      end
      if (acc_i && we_i && (addr_i == REG_RELOAD)) reload_q <= wdata_i;
      if (feed_i && stop_pend_q) begin
        run_q       <= 1'b0;
        stop_pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[REG_W-1 -: SEL_W] = sel_q;
        rdata_o[RUN_BIT]          = run_q;
        rdata_o[FLAG_BIT]         = flag_i;
      end
      REG_RELOAD: rdata_o = reload_q;
      default:    rdata_o = '0;
    endcase
  end

  assign sel_o    = sel_q;
  assign run_o    = run_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic expire_i,
  input  logic clr_i,
  output logic flag_o
);
  logic alive_q;
  logic alive_d_q;
  logic cause_q;
  logic flag_q;

  // low during system reset and until the first edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alive_q <= 1'b0;
    else         alive_q <= 1'b1;
  end

  // power-on domain: outlives the system reset it requested
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      alive_d_q <= 1'b0;
      cause_q   <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      alive_d_q <= alive_q;
      if (!alive_q)      flag_q <= cause_q;
      else if (expire_i) flag_q <= 1'b1;
      else if (clr_i)    flag_q <= 1'b0;
      if (expire_i)                    cause_q <= 1'b1;
      else if (alive_q && !alive_d_q)  cause_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int SEL_W    = 3,
  parameter int PRE_BASE = 5,
  parameter int DATA_W   = 16,
  parameter int REG_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              wd_rst_req_o
);
  localparam int CNT_W = REG_W;

  logic [REG_W-1:0] wdata_lo;
  logic             unused_hi_bits;
  logic             feed_ok;
  logic             flag;
  logic             flag_clr;
  logic [SEL_W-1:0] sel;
  logic             run;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             expire;
  logic             req_q;

  assign wdata_lo       = bus_wdata_i[REG_W-1:0];
  assign unused_hi_bits = ^bus_wdata_i[DATA_W-1:REG_W];

  wdog_feed_seq #(.REG_W(REG_W)) u_feed (
    .clk_i, .rst_ni, .acc_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(wdata_lo), .feed_o(feed_ok)
  );

  wdog_regs #(.REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .acc_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(wdata_lo), .feed_i(feed_ok), .flag_i(flag), .sel_o(sel), .run_o(run),
    .reload_o(reload), .flag_clr_o(flag_clr), .rdata_o(bus_rdata_o)
  );

  wdog_prescaler #(.SEL_W(SEL_W), .PRE_BASE(PRE_BASE)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .clear_i(feed_ok), .sel_i(sel), .tick_o(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(feed_ok), .tick_i(tick), .reload_i(reload),
    .expire_o(expire), .cnt_o(cnt)
  );

  wdog_cause u_cause (
    .clk_i, .rst_ni, .por_ni, .expire_i(expire), .clr_i(flag_clr), .flag_o(flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= expire;
  end

  assign wd_rst_req_o = req_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int REG_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             flag_i,
  input logic             run_i,
  input logic             feed_i,
  input logic [REG_W-1:0] cnt_i,
  input logic [REG_W-1:0] reload_i,
  input logic [REG_W-1:0] rd_i,
  input logic             acc_i,
  input logic             we_i,
  input logic [1:0]       addr_i
);
  p_req_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !req_i);

  p_req_sets_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> flag_i);

  p_no_req_stopped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !req_i);

  p_stop_at_feed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> $past(feed_i));

  p_feed_loads_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_i |=> (cnt_i == $past(reload_i)));

  p_ctrl_spare_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i && addr_i == 2'd0) |->
      (rd_i[REG_W-SEL_W-1:3] == '0 && rd_i[0] == 1'b0));
endmodule

bind wdog_top wdog_checker #(.REG_W(REG_W), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(wd_rst_req_o), .flag_i(flag),
  .run_i(run), .feed_i(feed_ok), .cnt_i(cnt), .reload_i(reload),
  .rd_i(bus_rdata_o), .acc_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i)
);

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        por_ni = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = 2'd0;
  logic [15:0] bus_wdata_i = 16'h0;
  logic [7:0]  bus_rdata_o;
  logic        wd_rst_req_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  wdog_top dut (.*);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int d);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #5 d = int'(bus_rdata_o);
    @(negedge clk_i);
    bus_sel_i = 1'b0;
  endtask

  task automatic feed(output int fc);
    bus_wr(2'd2, 16'h77A5);
    bus_wr(2'd3, 16'h905A);
    fc = cyc;
  endtask

  task automatic wait_req(input int limit, output int rc);
    rc = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_i);
      if (wd_rst_req_o) begin
        rc = cyc;
        break;
      end
    end
  endtask

  task automatic sys_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20ns * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL bench watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int d, c0, fc, rc, t, n;
    repeat (3) @(negedge clk_i);
    por_ni = 1'b1; rst_ni = 1'b1;
    c0 = cyc;

    bus_rd(2'd0, d); check("R1 ctrl after power-on", d, 'hE4);
    bus_rd(2'd1, d); check("R1 reload after power-on", d, 'h00);

    wait_req(5000, rc); check("R3 default period after reset", rc - c0, 4096);
    @(negedge clk_i);   check("R3 request one cycle", int'(wd_rst_req_o), 0);

    bus_rd(2'd0, d);    check("R5 flag set by timeout", d, 'hE6);
    bus_wr(2'd0, 16'h00E6);
    bus_rd(2'd0, d);    check("R5 writing 1 keeps flag", d, 'hE6);
    bus_wr(2'd0, 16'h00E4);
    bus_rd(2'd0, d);    check("R5 writing 0 clears flag", d, 'hE4);

    sys_reset();
    bus_rd(2'd0, d);    check("R2 ctrl after watchdog reset", d, 'hE6);
    bus_rd(2'd1, d);    check("R2 reload after watchdog reset", d, 'h00);
    sys_reset();
    bus_rd(2'd0, d);    check("R2 ctrl after other reset", d, 'hE4);

    bus_wr(2'd1, 16'hAB03);
    bus_rd(2'd1, d);    check("R7 reload low byte only", d, 'h03);
    bus_wr(2'd0, 16'h00FF);
    bus_rd(2'd0, d);    check("R7 spare ctrl bits read 0", d, 'hE4);
    bus_rd(2'd2, d);    check("R7 key A reads 0", d, 0);
    bus_rd(2'd3, d);    check("R7 key B reads 0", d, 0);

    // sweep every prescaler select over several reload values
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 3; k++) begin
        int r;
        r = (k == 2) ? 3 : k;
        t = (r + 1) * (32 << s);
        bus_wr(2'd1, 16'hC300 | 16'(r));
        bus_wr(2'd0, 16'((s << 5) | 4));
        feed(fc);
        wait_req(t + 8, rc);
        check($sformatf("R3 period sel=%0d reload=%0d", s, r), rc - fc, t);
        if (s <= 2) begin
          fc = rc;
          wait_req(t + 8, rc);
          check($sformatf("R8 free-run period sel=%0d reload=%0d", s, r), rc - fc, t);
        end
      end
    end

    // malformed restart sequences must not reload
    bus_wr(2'd1, 16'h0003);
    bus_wr(2'd0, 16'h0004);
    feed(fc);
    repeat (20) @(negedge clk_i);
    bus_wr(2'd2, 16'h00A5); bus_rd(2'd0, d); bus_wr(2'd3, 16'h005A);
    bus_wr(2'd2, 16'h00A5); bus_wr(2'd1, 16'h0003); bus_wr(2'd3, 16'h005A);
    bus_wr(2'd2, 16'h00A5); bus_wr(2'd3, 16'h005B);
    bus_wr(2'd3, 16'h005A);
    bus_wr(2'd2, 16'h00A4); bus_wr(2'd3, 16'h005A);
    wait_req(200, rc);
    check("R4 broken sequences do not restart", rc - fc, 128);

    // deferred stop
    feed(fc);
    bus_wr(2'd0, 16'h0000);
    bus_rd(2'd0, d);    check("R6 run held until restart", d, 'h04);
    wait_req(200, rc);
    check("R6 still expires before restart", rc - fc, 128);
    feed(fc);
    bus_rd(2'd0, d);    check("R6 run cleared by restart", d, 'h02);
    n = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_i);
      if (wd_rst_req_o) n++;
    end
    check("R6 no request while stopped", n, 0);
    bus_wr(2'd0, 16'h0004);
    fc = cyc;
    wait_req(200, rc);
    check("R6 run write restarts counting", rc - fc, 128);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule